// File: doc/BRIEF.md
# Base-Limit Region Protection Checker

This block screens every access a processor core makes against a set of programmable address windows. Each window is an arbitrary inclusive span from a base to a limit at 32-byte granularity. Each carries an access-permission code, an execute-never flag, an enable and a 3-bit index into a table of eight attribute bytes. For each request (address, kind, privilege level, handler context) the block answers in the same cycle. It reports whether the access faults, whether the fault came from two windows claiming the address, and the memory attribute byte that applies, decoded into a Device/Normal flag and a Device sub-type.

Software sets the windows up through a small register port. A selector register picks one window, and the base and limit registers then read and write that window only. A control register enables the checker, enables a default map for privileged accesses that match no window, and chooses whether checking stays on inside fault and non-maskable interrupt handlers. Two 32-bit registers hold the eight attribute bytes. Overlapping windows are not resolved by priority: any address claimed by two or more enabled windows faults.

Top module: `rguard_top`

## Requirements
- R1: After reset, the control, selector and all window registers read as zero, every window is disabled and no access faults.
- R2: While control bit 0 (enable) is clear, no access faults, whatever the windows hold.
- R3: A window hits an address when the window is enabled and {base[31:5],5'b00000} <= address <= {limit[31:5],5'b11111}, both bounds inclusive.
- R4: When two or more enabled windows hit, the access faults and resp_overlap is 1, whatever their permissions are. A single hit gives resp_overlap 0.
- R5: Base register bits [4:3] hold the permission code: 00 privileged read/write, 01 read/write at any level, 10 privileged read-only, 11 read-only at any level. An unprivileged access to a privileged-only window faults, and a write to a read-only window faults while reads of it succeed.
- R6: Base register bit 0 is execute-never. A fetch (req_kind 2) from such a window faults even when reads of it succeed.
- R7: When the checker is active and no window hits, an unprivileged access faults. A privileged access faults unless control bit 1 (default map) is set.
- R8: When req_in_handler is 1 and control bit 2 is clear, no access faults. When control bit 2 is set, handler accesses are checked as usual.
- R9: Register offsets on cfg_addr are 0 control, 1 selector, 2 base, 3 limit, 4 attribute bytes 0-3, 5 attribute bytes 4-7. Base and limit reads and writes reach only the window named by the selector. cfg_rdata presents the register at cfg_addr one cycle after it is sampled.
- R10: Limit register bits [3:1] index attribute byte k, which is bits [8k+7:8k] of {reg5,reg4}. On a single hit, resp_attr is that byte. resp_device is 1 when the byte's top nibble is zero, and resp_dev_type is then byte bits [3:2] (00 nGnRnE, 01 nGnRE, 10 nGRE, 11 GRE). With no single hit, resp_attr is 0. Limit bit 0 enables the window.
- R11: The lookup is combinational from the request to the response. A register write changes the lookup from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the register at cfg_addr |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| req_priv | input | 1 | Access is privileged |
| req_in_handler | input | 1 | Access comes from a fault or NMI handler |
| resp_fault | output | 1 | Access is refused |
| resp_overlap | output | 1 | Fault caused by multiple window hits |
| resp_attr | output | 8 | Resolved attribute byte |
| resp_device | output | 1 | Attribute is Device memory |
| resp_dev_type | output | 2 | Device sub-type |

## Verification
The assertions assume that the request inputs are stable around each rising edge and that cfg_wr is never asserted together with reset. The bench changes requests and register writes only on falling edges. It samples the combinational response one time step later and the registered read data after the following falling edge. It also keeps every written selector value inside the window count, so the one-slot write-strobe check stays meaningful.

// File: rtl/rguard_pkg.sv
package rguard_pkg;

  localparam int DATA_W   = 32;
  localparam int ATTR_NUM = 8;
  localparam int AIDX_W   = 3;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_SEL   = 3'd1;
  localparam logic [2:0] OFS_BASE  = 3'd2;
  localparam logic [2:0] OFS_LIMIT = 3'd3;
  localparam logic [2:0] OFS_ATLO  = 3'd4;
  localparam logic [2:0] OFS_ATHI  = 3'd5;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic [1:0]        perm;
    logic              xn;
    logic [AIDX_W-1:0] aidx;
  } slot_attr_t;

endpackage

// File: rtl/rguard_slot.sv
module rguard_slot
  import rguard_pkg::*;
#(
  parameter int GRAN_BITS = 5,
  localparam int BLK_W = DATA_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base,
  input  logic              wr_limit,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [1:0]        wr_perm,
  input  logic              wr_xn,
  input  logic [AIDX_W-1:0] wr_aidx,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  look_blk,
  output logic              hit,
  output slot_attr_t        attr,
  output logic [DATA_W-1:0] base_rd,
  output logic [DATA_W-1:0] limit_rd
);

  logic [BLK_W-1:0]  base_q, lim_q;
  logic [1:0]        perm_q;
  logic              xn_q, en_q;
  logic [AIDX_W-1:0] aidx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      perm_q <= '0;
      xn_q   <= 1'b0;
      lim_q  <= '0;
      aidx_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_base) begin
        base_q <= wr_blk;
        perm_q <= wr_perm;
        xn_q   <= wr_xn;
      end
      if (wr_limit) begin
        lim_q  <= wr_blk;
        aidx_q <= wr_aidx;
        en_q   <= wr_en;
      end
    end
  end

  // Inclusive compare on block numbers: low bits of base are zeros, of limit ones.
  assign hit  = en_q && (look_blk >= base_q) && (look_blk <= lim_q);
  assign attr = '{perm: perm_q, xn: xn_q, aidx: aidx_q};

  always_comb begin
    base_rd = '0;
    base_rd[DATA_W-1:GRAN_BITS] = base_q;
    base_rd[4:3] = perm_q;
    base_rd[0]   = xn_q;
    limit_rd = '0;
    limit_rd[DATA_W-1:GRAN_BITS] = lim_q;
    limit_rd[3:1] = aidx_q;
    limit_rd[0]   = en_q;
  end

  // R11: a base write is in force from the capturing edge
  a_r11_base_load: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> (base_q == $past(wr_blk)) && (perm_q == $past(wr_perm)));

  // R1: reset leaves the window disabled
  a_r1_reset_disabled: assert property (@(posedge clk)
    $past(rst) |-> !en_q);

endmodule

// File: rtl/rguard_cfg.sv
module rguard_cfg
  import rguard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_wr,
  input  logic [2:0]                         cfg_addr,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  output logic [DATA_W-1:0]                  cfg_rdata,
  input  logic [NUM_REGIONS-1:0][DATA_W-1:0] base_rd,
  input  logic [NUM_REGIONS-1:0][DATA_W-1:0] limit_rd,
  output logic [NUM_REGIONS-1:0]             wr_base_vec,
  output logic [NUM_REGIONS-1:0]             wr_limit_vec,
  output logic [2:0]                         ctrl,
  output logic [2*DATA_W-1:0]                attr_bank
);

  logic [IDX_W-1:0]  sel_q;
  logic [2:0]        ctrl_q;
  logic [DATA_W-1:0] atlo_q, athi_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      ctrl_q <= '0;
      atlo_q <= '0;
      athi_q <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        OFS_CTRL: ctrl_q <= cfg_wdata[2:0];
        OFS_SEL:  sel_q  <= cfg_wdata[IDX_W-1:0];
        OFS_ATLO: atlo_q <= cfg_wdata;
        OFS_ATHI: athi_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_strobe
    assign wr_base_vec[i]  = cfg_wr && (cfg_addr == OFS_BASE)  && (sel_q == IDX_W'(i));
    assign wr_limit_vec[i] = cfg_wr && (cfg_addr == OFS_LIMIT) && (sel_q == IDX_W'(i));
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL:  rd_mux = {{(DATA_W-3){1'b0}}, ctrl_q};
      OFS_SEL:   rd_mux = DATA_W'(sel_q);
      OFS_BASE:  rd_mux = base_rd[sel_q];
      OFS_LIMIT: rd_mux = limit_rd[sel_q];
      OFS_ATLO:  rd_mux = atlo_q;
      OFS_ATHI:  rd_mux = athi_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

  assign ctrl      = ctrl_q;
  assign attr_bank = {athi_q, atlo_q};

  // R9: selector follows the written value
  a_r9_sel_follows: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == OFS_SEL) |=> sel_q == $past(cfg_wdata[IDX_W-1:0]));

  // R9: at most one window receives a base or limit write
  a_r9_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_base_vec) && $onehot0(wr_limit_vec));

endmodule

// File: rtl/rguard_resolve.sv
module rguard_resolve
  import rguard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0]              hit_vec,
  input  slot_attr_t [NUM_REGIONS-1:0]        slot_attr,
  input  logic [2:0]                          ctrl,
  input  logic [2*DATA_W-1:0]                 attr_bank,
  input  logic [1:0]                          req_kind,
  input  logic                                req_priv,
  input  logic                                req_in_handler,
  output logic                                fault,
  output logic                                overlap,
  output logic [7:0]                          attr_byte,
  output logic                                device,
  output logic [1:0]                          dev_type
);

  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  logic [CNT_W-1:0] hit_cnt;
  slot_attr_t       win;
  logic             active, single, perm_bad;

  always_comb begin
    hit_cnt = '0;
    win     = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
      if (hit_vec[i]) win = win | slot_attr[i];
    end
  end

  assign active = ctrl[0] && !(req_in_handler && !ctrl[2]);
  assign single = (hit_cnt == CNT_W'(1));

  always_comb begin
    perm_bad = 1'b0;
    if (win.perm[1] && (req_kind == KIND_WRITE)) perm_bad = 1'b1;
    if (!win.perm[0] && !req_priv)               perm_bad = 1'b1;
    if (win.xn && (req_kind == KIND_FETCH))      perm_bad = 1'b1;
  end

  always_comb begin
    overlap = active && (hit_cnt > CNT_W'(1));
    if (!active)      fault = 1'b0;
    else if (overlap) fault = 1'b1;
    else if (single)  fault = perm_bad;
    else              fault = !(req_priv && ctrl[1]);
  end

  assign attr_byte = single ? attr_bank[win.aidx*8 +: 8] : 8'h00;
  assign device    = (attr_byte[7:4] == 4'h0);
  assign dev_type  = device ? attr_byte[3:2] : 2'b00;

endmodule

// File: rtl/rguard_top.sv
module rguard_top
  import rguard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int GRAN_BITS   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_kind,
  input  logic        req_priv,
  input  logic        req_in_handler,
  output logic        resp_fault,
  output logic        resp_overlap,
  output logic [7:0]  resp_attr,
  output logic        resp_device,
  output logic [1:0]  resp_dev_type
);

  localparam int BLK_W = DATA_W - GRAN_BITS;

  logic [NUM_REGIONS-1:0][DATA_W-1:0] base_rd, limit_rd;
  logic [NUM_REGIONS-1:0]             wr_base_vec, wr_limit_vec, hit_vec;
  slot_attr_t [NUM_REGIONS-1:0]       slot_attr;
  logic [2:0]                         ctrl;
  logic [2*DATA_W-1:0]                attr_bank;

  rguard_cfg #(.NUM_REGIONS(NUM_REGIONS)) u_cfg (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .base_rd, .limit_rd, .wr_base_vec, .wr_limit_vec, .ctrl, .attr_bank
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    rguard_slot #(.GRAN_BITS(GRAN_BITS)) u_slot (
      .clk, .rst,
      .wr_base  (wr_base_vec[i]),
      .wr_limit (wr_limit_vec[i]),
      .wr_blk   (cfg_wdata[DATA_W-1:GRAN_BITS]),
      .wr_perm  (cfg_wdata[4:3]),
      .wr_xn    (cfg_wdata[0]),
      .wr_aidx  (cfg_wdata[3:1]),
      .wr_en    (cfg_wdata[0]),
      .look_blk (req_addr[DATA_W-1:GRAN_BITS]),
      .hit      (hit_vec[i]),
      .attr     (slot_attr[i]),
      .base_rd  (base_rd[i]),
      .limit_rd (limit_rd[i])
    );
  end

  rguard_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_resolve (
    .hit_vec, .slot_attr, .ctrl, .attr_bank, .req_kind, .req_priv, .req_in_handler,
    .fault    (resp_fault),
    .overlap  (resp_overlap),
    .attr_byte(resp_attr),
    .device   (resp_device),
    .dev_type (resp_dev_type)
  );

  logic bypass;
  assign bypass = req_in_handler && !ctrl[2];

  // R2: a disabled checker never refuses
  a_r2_off_allows: assert property (@(posedge clk) disable iff (rst)
    !ctrl[0] |-> !resp_fault);

  // R4: multiple window hits always fault
  a_r4_overlap_faults: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && !bypass && $countones(hit_vec) > 1) |-> (resp_fault && resp_overlap));

  // R7: unprivileged miss faults
  a_r7_unpriv_miss: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && !bypass && hit_vec == '0 && !req_priv) |-> resp_fault);

  // R8: bypassed handler accesses are never refused
  a_r8_handler_bypass: assert property (@(posedge clk) disable iff (rst)
    bypass |-> !resp_fault);

  // R10: no window, no attribute
  a_r10_no_hit_attr: assert property (@(posedge clk) disable iff (rst)
    (hit_vec == '0) |-> (resp_attr == 8'h00));

  localparam int UNUSED_BLK = BLK_W;

endmodule

// File: tb/tb_rguard_top.sv
module tb_rguard_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic        req_in_handler = 1'b0;
  logic        resp_fault, resp_overlap, resp_device;
  logic [7:0]  resp_attr;
  logic [1:0]  resp_dev_type;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rguard_top dut (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_addr, .req_kind, .req_priv, .req_in_handler,
    .resp_fault, .resp_overlap, .resp_attr, .resp_device, .resp_dev_type
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] ofs, input logic [31:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] ofs, output logic [31:0] val);
    @(negedge clk);
    cfg_addr = ofs;
    @(posedge clk);
    @(negedge clk);
    val = cfg_rdata;
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic p, input logic h);
    req_addr = a; req_kind = k; req_priv = p; req_in_handler = h;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(3'd0, v); chk("R1 ctrl after reset", v, 32'h0);
    rd_reg(3'd2, v); chk("R1 base after reset", v, 32'h0);
    look(32'h2000_6000, WR, 1'b0, 1'b0);
    chk("R1 no fault after reset", resp_fault, 0);
  endtask

  task automatic t_disabled;
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd2, 32'h2000_6018);
    wr_reg(3'd3, 32'h2000_6FE1);
    look(32'h2000_6000, WR, 1'b0, 1'b0);
    chk("R2 disabled unpriv write to RO", resp_fault, 0);
    look(32'h4000_0000, FE, 1'b0, 1'b0);
    chk("R2 disabled unpriv miss", resp_fault, 0);
  endtask

  task automatic t_bounds;
    wr_reg(3'd0, 32'd1);
    look(32'h2000_6000, RD, 1'b0, 1'b0); chk("R3 base inclusive", resp_fault, 0);
    look(32'h2000_6FFF, RD, 1'b0, 1'b0); chk("R3 limit low bits ones", resp_fault, 0);
    look(32'h2000_7000, RD, 1'b0, 1'b0); chk("R3 above limit misses", resp_fault, 1);
    look(32'h2000_5FFF, RD, 1'b0, 1'b0); chk("R3 below base misses", resp_fault, 1);
    wr_reg(3'd3, 32'h2000_7FE1);
    look(32'h2000_7000, RD, 1'b0, 1'b0); chk("R11 new limit in force", resp_fault, 0);
    wr_reg(3'd3, 32'h2000_6FE1);
    look(32'h2000_7000, RD, 1'b0, 1'b0); chk("R11 limit restored", resp_fault, 1);
  endtask

  task automatic t_perms;
    look(32'h2000_6040, WR, 1'b0, 1'b0); chk("R5 ro-any unpriv write", resp_fault, 1);
    look(32'h2000_6040, RD, 1'b0, 1'b0); chk("R5 ro-any unpriv read", resp_fault, 0);
    wr_reg(3'd2, 32'h2000_6000);
    look(32'h2000_6040, RD, 1'b0, 1'b0); chk("R5 priv-rw unpriv read", resp_fault, 1);
    look(32'h2000_6040, WR, 1'b1, 1'b0); chk("R5 priv-rw priv write", resp_fault, 0);
    wr_reg(3'd2, 32'h2000_6008);
    look(32'h2000_6040, WR, 1'b0, 1'b0); chk("R5 rw-any unpriv write", resp_fault, 0);
    wr_reg(3'd2, 32'h2000_6010);
    look(32'h2000_6040, RD, 1'b1, 1'b0); chk("R5 priv-ro priv read", resp_fault, 0);
    look(32'h2000_6040, WR, 1'b1, 1'b0); chk("R5 priv-ro priv write", resp_fault, 1);
    look(32'h2000_6040, RD, 1'b0, 1'b0); chk("R5 priv-ro unpriv read", resp_fault, 1);
  endtask

  task automatic t_xn;
    wr_reg(3'd2, 32'h2000_6009);
    look(32'h2000_6100, FE, 1'b0, 1'b0); chk("R6 fetch from xn", resp_fault, 1);
    look(32'h2000_6100, RD, 1'b0, 1'b0); chk("R6 read from xn", resp_fault, 0);
    wr_reg(3'd2, 32'h2000_6008);
    look(32'h2000_6100, FE, 1'b0, 1'b0); chk("R6 fetch without xn", resp_fault, 0);
  endtask

  task automatic t_background;
    look(32'h3000_0000, RD, 1'b1, 1'b0); chk("R7 priv miss without map", resp_fault, 1);
    wr_reg(3'd0, 32'd3);
    look(32'h3000_0000, RD, 1'b1, 1'b0); chk("R7 priv miss with map", resp_fault, 0);
    look(32'h3000_0000, RD, 1'b0, 1'b0); chk("R7 unpriv miss with map", resp_fault, 1);
  endtask

  task automatic t_overlap;
    wr_reg(3'd1, 32'd1);
    wr_reg(3'd2, 32'h2000_5008);
    wr_reg(3'd3, 32'h2000_7FE7);
    look(32'h2000_6000, RD, 1'b1, 1'b0);
    chk("R4 overlap fault", resp_fault, 1);
    chk("R4 overlap flag", resp_overlap, 1);
    look(32'h2000_5000, RD, 1'b1, 1'b0);
    chk("R4 single hit allowed", resp_fault, 0);
    chk("R4 single hit no flag", resp_overlap, 0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    rd_reg(3'd1, v); chk("R9 selector readback", v, 32'd1);
    rd_reg(3'd2, v); chk("R9 window1 base", v, 32'h2000_5008);
    rd_reg(3'd3, v); chk("R9 window1 limit", v, 32'h2000_7FE7);
    wr_reg(3'd1, 32'd0);
    rd_reg(3'd2, v); chk("R9 window0 base untouched", v, 32'h2000_6008);
    rd_reg(3'd3, v); chk("R9 window0 limit untouched", v, 32'h2000_6FE1);
    wr_reg(3'd1, 32'd1);
  endtask

  task automatic t_attr;
    logic [31:0] v;
    wr_reg(3'd4, 32'hFF08_0400);
    wr_reg(3'd5, 32'h0C0C_0C44);
    rd_reg(3'd5, v); chk("R9 attr high readback", v, 32'h0C0C_0C44);
    look(32'h2000_5000, RD, 1'b1, 1'b0);
    chk("R10 idx3 attr", resp_attr, 8'hFF);
    chk("R10 idx3 normal", resp_device, 0);
    wr_reg(3'd3, 32'h2000_7FE5);
    chk("R10 idx2 attr", resp_attr, 8'h08);
    chk("R10 idx2 device", resp_device, 1);
    chk("R10 idx2 nGRE", resp_dev_type, 2'b10);
    wr_reg(3'd3, 32'h2000_7FE9);
    chk("R10 idx4 attr", resp_attr, 8'h44);
    chk("R10 idx4 normal", resp_device, 0);
    wr_reg(3'd3, 32'h2000_7FEF);
    chk("R10 idx7 attr", resp_attr, 8'h0C);
    chk("R10 idx7 GRE", resp_dev_type, 2'b11);
    wr_reg(3'd3, 32'h2000_7FE1);
    chk("R10 idx0 attr", resp_attr, 8'h00);
    chk("R10 idx0 nGnRnE device", resp_device, 1);
    look(32'h3000_0000, RD, 1'b1, 1'b0);
    chk("R10 miss gives zero attr", resp_attr, 8'h00);
  endtask

  task automatic t_handler;
    look(32'h2000_6000, RD, 1'b0, 1'b1);
    chk("R8 handler bypass on overlap", resp_fault, 0);
    wr_reg(3'd0, 32'd7);
    look(32'h2000_6000, RD, 1'b0, 1'b1);
    chk("R8 handler checked when kept", resp_fault, 1);
    look(32'h2000_6000, RD, 1'b0, 1'b0);
    chk("R8 non-handler still checked", resp_fault, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_bounds();
    t_perms();
    t_xn();
    t_background();
    t_overlap();
    t_select();
    t_attr();
    t_handler();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule